// File: doc/BRIEF.md
# Predication Table Decoder

This block keeps a small bank of sixteen key-value configuration words and expands them into two dense lookup tables of 32 slots each. One table serves the integer register file and the other serves the floating-point register file. Each configuration word names one register, the "key". When that register is used, the word says which register holds its predicate mask, whether the mask is inverted, and whether elements the mask leaves out are written as zero.

Every write to the bank starts a rebuild. The rebuild first clears all 64 slots of a shadow copy. It then applies the configuration words one per cycle, in ascending index order. Last, it moves the shadow copy into the live tables in a single cycle. The lookup port is purely combinational and always reads the live tables, so consumers see either the complete old table or the complete new one, never a mix.

Top module: `pred_table_decoder`

## Requirements
- R1: After reset, busy is 0 and a lookup of any of the 64 slots returns enable 0, predicate register 0, invert 0 and zero 0.
- R2: A configuration word is 14 bits wide. Bit 13 is valid. Bit 12 is the file select (0 integer, 1 floating-point). Bits 11:7 are the key register. Bits 6:2 are the predicate register. Bit 1 is invert and bit 0 is zero. Writing it to entry cfg_idx stores it.
- R3: Once a rebuild has finished, a lookup of (lk_fp, lk_reg) for a slot keyed by an applied word returns enable 1, together with that word's predicate register, invert and zero fields, in the same cycle.
- R4: When several valid words carry the same file and key, the word with the highest entry index sets the slot.
- R5: A word whose valid bit is 0 leaves every slot unaffected.
- R6: Every rebuild starts from an empty table. A slot whose last keying word has been invalidated or re-keyed reads as disabled afterwards.
- R7: busy goes high in the cycle after a configuration write and stays high for NUM_CFG+2 cycles. Until it falls, lookups return the previous table contents; the new contents appear in the cycle busy falls.
- R8: A configuration write during a rebuild restarts it. The new table appears NUM_CFG+2 cycles after the latest write, and busy stays high until then.
- R9: A lookup of a slot with enable 0 returns 0 in the predicate register, invert and zero outputs.
- R10: The integer and floating-point tables are independent: the same key in the two files holds different settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | $clog2(NUM_CFG) | Entry index written |
| cfg_wdata | input | 14 | Configuration word (layout in R2) |
| lk_fp | input | 1 | Lookup file select: 0 integer, 1 floating-point |
| lk_reg | input | 5 | Lookup register number |
| lk_en | output | 1 | Slot is predicated |
| lk_preg | output | 5 | Register holding the predicate mask |
| lk_inv | output | 1 | Mask is inverted |
| lk_zero | output | 1 | Non-predicated elements are zeroed |
| busy | output | 1 | Rebuild in progress |

## Verification
The bench builds the block with its defaults: sixteen entries and 5-bit register numbers, which gives 32 slots per file. With these values, entry 15 can be pitted against lower entries for the same key, and the full 64-slot sweep after reset takes only a short run. An 18-cycle rebuild window is long enough to place a second write mid-rebuild, so the bench can show that the first write's commit point passes without a table change.

// File: rtl/pdt_pkg.sv
`timescale 1ns/1ps
package pdt_pkg;
  localparam int REG_W     = 5;
  localparam int NUM_REGS  = 1 << REG_W;
  localparam int NUM_FILES = 2;

  typedef struct packed {
    logic             valid;
    logic             file;
    logic [REG_W-1:0] key;
    logic [REG_W-1:0] preg;
    logic             inv;
    logic             zero;
  } cfg_entry_t;

  localparam int CFG_W = $bits(cfg_entry_t);

  typedef struct packed {
    logic             en;
    logic [REG_W-1:0] preg;
    logic             inv;
    logic             zero;
  } slot_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CLEAR  = 2'd1,
    ST_APPLY  = 2'd2,
    ST_COMMIT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pdt_cfg_bank.sv
`timescale 1ns/1ps
module pdt_cfg_bank
  import pdt_pkg::*;
#(
  parameter  int NUM_CFG = 16,
  localparam int IDX_W   = $clog2(NUM_CFG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  cfg_entry_t       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output cfg_entry_t       rd_data
);

  cfg_entry_t [NUM_CFG-1:0] bank_all;

  // one register per entry, each with its own write enable
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_entry
    cfg_entry_t ent_q;
    cfg_entry_t ent_d;
    logic       ent_ce;

    always_comb begin
      ent_ce = wr_en && (wr_idx == IDX_W'(g));
      ent_d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_ce) begin
        ent_q <= ent_d;
      end
    end

    assign bank_all[g] = ent_q;
  end

  assign rd_data = bank_all[rd_idx];

endmodule

// File: rtl/pdt_seq.sv
`timescale 1ns/1ps
module pdt_seq
  import pdt_pkg::*;
#(
  parameter  int NUM_CFG = 16,
  localparam int IDX_W   = $clog2(NUM_CFG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             clr,
  output logic             apply,
  output logic             commit,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CFG - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    clr     = 1'b0;
    apply   = 1'b0;
    commit  = 1'b0;
    unique case (state_q)
      ST_IDLE: ;
      ST_CLEAR: begin
        clr     = 1'b1;
        idx_d   = '0;
        state_d = ST_APPLY;
      end
      ST_APPLY: begin
        apply = 1'b1;
        if (idx_q == LAST_IDX) begin
          state_d = ST_COMMIT;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_COMMIT: begin
        // a write landing on the commit cycle makes the shadow stale
        commit  = !start;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (start) begin
      state_d = ST_CLEAR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign idx  = idx_q;

endmodule

// File: rtl/pdt_table.sv
`timescale 1ns/1ps
module pdt_table
  import pdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [REG_W-1:0] wr_key,
  input  slot_t            wr_slot,
  input  logic             commit,
  input  logic [REG_W-1:0] rd_key,
  output slot_t            rd_slot
);

  slot_t [NUM_REGS-1:0] live_all;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    slot_t sh_q, sh_d, live_q;
    logic  sh_hit, sh_ce;

    always_comb begin
      sh_hit = wr && (wr_key == REG_W'(g));
      sh_ce  = clr || sh_hit;
      sh_d   = clr ? '0 : wr_slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '0;
      end else if (sh_ce) begin
        sh_q <= sh_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q <= '0;
      end else if (commit) begin
        live_q <= sh_q;
      end
    end

    assign live_all[g] = live_q;
  end

  assign rd_slot = live_all[rd_key];

endmodule

// File: rtl/pred_table_decoder.sv
`timescale 1ns/1ps
module pred_table_decoder
  import pdt_pkg::*;
#(
  parameter  int NUM_CFG = 16,
  localparam int IDX_W   = $clog2(NUM_CFG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             lk_fp,
  input  logic [REG_W-1:0] lk_reg,
  output logic             lk_en,
  output logic [REG_W-1:0] lk_preg,
  output logic             lk_inv,
  output logic             lk_zero,
  output logic             busy
);

  logic             seq_clr, seq_apply, seq_commit;
  logic [IDX_W-1:0] seq_idx;
  cfg_entry_t       cur_ent;
  slot_t            cur_slot;
  slot_t [NUM_FILES-1:0] file_rd;
  slot_t            sel_slot;

  pdt_cfg_bank #(.NUM_CFG(NUM_CFG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_entry_t'(cfg_wdata)),
    .rd_idx  (seq_idx),
    .rd_data (cur_ent)
  );

  pdt_seq #(.NUM_CFG(NUM_CFG)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (cfg_we),
    .busy   (busy),
    .clr    (seq_clr),
    .apply  (seq_apply),
    .commit (seq_commit),
    .idx    (seq_idx)
  );

  always_comb begin
    cur_slot.en   = 1'b1;
    cur_slot.preg = cur_ent.preg;
    cur_slot.inv  = cur_ent.inv;
    cur_slot.zero = cur_ent.zero;
  end

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    logic file_wr;
    assign file_wr = seq_apply && cur_ent.valid && (cur_ent.file == 1'(f));

    pdt_table u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (seq_clr),
      .wr      (file_wr),
      .wr_key  (cur_ent.key),
      .wr_slot (cur_slot),
      .commit  (seq_commit),
      .rd_key  (lk_reg),
      .rd_slot (file_rd[f])
    );
  end

  assign sel_slot = file_rd[lk_fp];
  assign lk_en    = sel_slot.en;
  assign lk_preg  = sel_slot.preg;
  assign lk_inv   = sel_slot.inv;
  assign lk_zero  = sel_slot.zero;

endmodule

// File: rtl/pdt_checker.sv
`timescale 1ns/1ps
module pdt_checker #(
  parameter int NUM_CFG = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       lk_fp,
  input logic [4:0] lk_reg,
  input logic       lk_en,
  input logic [4:0] lk_preg,
  input logic       lk_inv,
  input logic       lk_zero,
  input logic       busy
);

  localparam int RUN_W   = $clog2(NUM_CFG + 4) + 1;
  localparam int REBUILD = NUM_CFG + 2;

  logic [RUN_W-1:0] run_q;

  // busy cycles seen since the latest write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (cfg_we) begin
      run_q <= '0;
    end else if (busy) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r1_idle_in_reset: assert (!busy);
    end
  end

  a_r7_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> busy);

  a_r7_old_table_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(lk_fp) && $stable(lk_reg))
      |-> $stable({lk_en, lk_preg, lk_inv, lk_zero}));

  a_r7_rebuild_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_W'(REBUILD));

  a_r8_rebuild_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == RUN_W'(REBUILD)) |-> !busy);

  a_r9_disabled_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |-> (lk_preg == 5'd0 && !lk_inv && !lk_zero));

endmodule

bind pred_table_decoder pdt_checker #(.NUM_CFG(NUM_CFG)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_we  (cfg_we),
  .lk_fp   (lk_fp),
  .lk_reg  (lk_reg),
  .lk_en   (lk_en),
  .lk_preg (lk_preg),
  .lk_inv  (lk_inv),
  .lk_zero (lk_zero),
  .busy    (busy)
);

// File: tb/pred_table_decoder_bench.sv
`timescale 1ns/1ps
module pred_table_decoder_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [13:0] cfg_wdata = '0;
  logic       lk_fp = 1'b0;
  logic [4:0] lk_reg = '0;
  logic       lk_en, lk_inv, lk_zero, busy;
  logic [4:0] lk_preg;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  pred_table_decoder u_pred_table_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .lk_fp(lk_fp), .lk_reg(lk_reg),
    .lk_en(lk_en), .lk_preg(lk_preg), .lk_inv(lk_inv), .lk_zero(lk_zero),
    .busy(busy)
  );

  // ---------------- behavioural reference ----------------
  logic [13:0] m_cfg [16];
  int  m_left;
  bit  m_en   [2][32];
  int  m_preg [2][32];
  bit  m_inv  [2][32];
  bit  m_zero [2][32];

  task automatic m_clear();
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < 32; r++) begin
        m_en[f][r] = 0; m_preg[f][r] = 0; m_inv[f][r] = 0; m_zero[f][r] = 0;
      end
  endtask

  task automatic m_rebuild();
    m_clear();
    for (int i = 0; i < 16; i++) begin
      if (m_cfg[i][13]) begin
        int f, k;
        f = m_cfg[i][12];
        k = m_cfg[i][11:7];
        m_en[f][k]   = 1;
        m_preg[f][k] = m_cfg[i][6:2];
        m_inv[f][k]  = m_cfg[i][1];
        m_zero[f][k] = m_cfg[i][0];
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_cfg[i] = '0;
      m_left = 0;
      m_clear();
    end else if (cfg_we) begin
      m_cfg[cfg_idx] = cfg_wdata;
      m_left = 18;
    end else if (m_left > 0) begin
      m_left--;
      if (m_left == 0) m_rebuild();
    end
  end

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R7", "busy", busy, m_left > 0);
      chk("R3", "lk_en", lk_en, m_en[lk_fp][lk_reg]);
      chk("R3", "lk_preg", lk_preg, m_preg[lk_fp][lk_reg]);
      chk("R3", "lk_inv", lk_inv, m_inv[lk_fp][lk_reg]);
      chk("R3", "lk_zero", lk_zero, m_zero[lk_fp][lk_reg]);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [13:0] word(bit v, bit f, int k, int p, bit i, bit z);
    return {v, f, 5'(k), 5'(p), i, z};
  endfunction

  task automatic wr(int idx, logic [13:0] w);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = w;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (22) @(posedge clk);
  endtask

  task automatic exp_lk(string tag, bit fp, int r, bit en, int p, bit i, bit z);
    @(posedge clk); #1;
    lk_fp = fp; lk_reg = 5'(r);
    @(negedge clk);
    chk(tag, "en", lk_en, en);
    chk(tag, "preg", lk_preg, p);
    chk(tag, "inv", lk_inv, i);
    chk(tag, "zero", lk_zero, z);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    started = 1;

    // R1: everything empty after reset
    @(negedge clk);
    chk("R1", "busy", busy, 0);
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < 32; r++)
        exp_lk("R1", f[0], r, 0, 0, 0, 0);

    // R2/R7: write, busy next cycle, old contents during rebuild
    lk_fp = 0; lk_reg = 5'd3;
    wr(0, word(1, 0, 3, 7, 1, 0));
    @(negedge clk);
    chk("R7", "busy after write", busy, 1);
    chk("R7", "old content during rebuild", lk_en, 0);
    settle();
    exp_lk("R2", 0, 3, 1, 7, 1, 0);

    // R10: same key, other file
    exp_lk("R10", 1, 3, 0, 0, 0, 0);
    wr(1, word(1, 1, 3, 9, 0, 1));
    settle();
    exp_lk("R10", 1, 3, 1, 9, 0, 1);
    exp_lk("R10", 0, 3, 1, 7, 1, 0);

    // R4: overlapping keys, highest index wins
    wr(5, word(1, 0, 3, 12, 0, 0));
    settle();
    exp_lk("R4", 0, 3, 1, 12, 0, 0);
    wr(15, word(1, 0, 3, 30, 0, 1));
    settle();
    exp_lk("R4", 0, 3, 1, 30, 0, 1);

    // R5: invalid word has no effect
    wr(15, word(0, 0, 3, 30, 0, 1));
    settle();
    exp_lk("R5", 0, 3, 1, 12, 0, 0);
    wr(7, word(0, 1, 20, 4, 1, 1));
    settle();
    exp_lk("R5", 1, 20, 0, 0, 0, 0);

    // R6: re-keying leaves the old slot disabled
    wr(1, word(1, 1, 8, 9, 0, 1));
    settle();
    exp_lk("R6", 1, 3, 0, 0, 0, 0);
    exp_lk("R6", 1, 8, 1, 9, 0, 1);

    // R8: write during rebuild restarts it
    wr(2, word(1, 0, 10, 1, 1, 1));
    repeat (5) @(posedge clk);
    wr(6, word(1, 0, 11, 2, 0, 1));
    lk_fp = 0; lk_reg = 5'd10;
    repeat (11) @(posedge clk);
    @(negedge clk);
    chk("R8", "busy at first commit point", busy, 1);
    chk("R8", "old content at first commit point", lk_en, 0);
    settle();
    exp_lk("R8", 0, 10, 1, 1, 1, 1);
    exp_lk("R8", 0, 11, 1, 2, 0, 1);

    // R9: untouched slot reads all zero
    exp_lk("R9", 0, 31, 0, 0, 0, 0);
    exp_lk("R9", 1, 0, 0, 0, 0, 0);

    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule